// File: doc/BRIEF.md
# Calendar Clock Register File

This block keeps the time of day and the calendar as packed-BCD counters that advance once per one-second tick pulse. Seconds roll into minutes, minutes into hours, and hours into day of week and date. The date rolls into the month after the last day of that month, and the month rolls into a two-digit year. The bus front end reaches the block through a simple synchronous write port and a combinational read port of nine byte registers. The counters are cleared only by the power-on reset of the backup domain, so bus activity never disturbs them.

Three control bits govern access. Setting the snapshot bit freezes a coherent copy of all seven counters, and every read of a time register returns that copy. Setting the hold bit stops counting and copies the counters into a holding image. While the bit is set, writes edit the holding image, and clearing the bit loads the image into the counters in one cycle. A stop bit makes the block ignore ticks. Calibration sign and magnitude and a tamper-enable bit are stored and read back. They do not affect counting.

Top module: `calendar_regfile`

## Requirements
- R1: Registers sit at addresses 0 control, 1 calibration, 2 seconds, 3 minutes, 4 hours, 5 day of week, 6 date, 7 month, 8 years. Addresses 9 to 15 read 0x00, and bits without a function read 0.
- R2: Each tick counts seconds in BCD. Seconds 59 wraps to 00 and carries into minutes, minutes 59 wraps to 00 and carries into hours, and hours 23 wraps to 00 and carries into the day fields.
- R3: Day of week runs 1 to 7, advances on every hours wrap, and wraps from 7 to 1.
- R4: After the last day of the month the date goes to 01 and the month advances. The last day is 31 for months 1, 3, 5, 7, 8, 10 and 12, and 30 for months 4, 6, 9 and 11. For month 2 it is 29 when the year is divisible by 4 and 28 otherwise.
- R5: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00.
- R6: Control bit 7 is the stop bit. While it reads 1, ticks are ignored and all counters hold.
- R7: Control bit 0 is the snapshot bit. A write that moves it from 0 to 1 copies the counters as they stood before that clock edge. Reads of addresses 2 to 8 always return this copy, which changes only on the next 0-to-1 move.
- R8: Control bit 1 is the hold bit. A write that moves it from 0 to 1 copies the counters into the holding image. While it is 1, ticks are ignored and writes to addresses 2 to 8 edit the image. A write that clears it loads the image into the counters. Writes to addresses 2 to 8 while it is 0 are ignored.
- R9: Calibration bit 5 is the sign and bits 4:0 are the magnitude. Control bit 6 is the tamper enable. These bits are stored, read back, and do not change counting.
- R10: After reset every control and calibration bit is 0 and the time is 00:00:00, day 1, date 01, month 01, year 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset, released synchronously inside |
| tick_i | input | 1 | One-cycle pulse per second |
| wr_en_i | input | 1 | Write strobe for addr_i/wdata_i |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |

## Verification
The range and wrap assertions assume that every value written into a time field is legal BCD within that field's range, and that the date written fits the month and year written with it. The bench writes only such values and always sets the hold bit around time writes. The bench keeps tick and write strobes one cycle wide. It follows each corner case (month ends, leap February, year wrap, stop bit, snapshot freeze) with a snapshot and a read of every register.

// File: rtl/calreg_pkg.sv
package calreg_pkg;
  localparam int NFIELD = 7;
  localparam int NREG   = NFIELD + 2;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_DATE = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;

  typedef logic [7:0] bcd_t;

  function automatic bcd_t field_mask(int idx);
    case (idx)
      F_SEC, F_MIN:    return 8'h7F;
      F_HOUR, F_DATE:  return 8'h3F;
      F_DAY:           return 8'h07;
      F_MON:           return 8'h1F;
      default:         return 8'hFF;
    endcase
  endfunction

  function automatic bcd_t field_first(int idx);
    case (idx)
      F_DAY, F_DATE, F_MON: return 8'h01;
      default:              return 8'h00;
    endcase
  endfunction

  function automatic bcd_t field_last(int idx);
    case (idx)
      F_SEC, F_MIN: return 8'h59;
      F_HOUR:       return 8'h23;
      F_DAY:        return 8'h07;
      F_DATE:       return 8'h31;
      F_MON:        return 8'h12;
      default:      return 8'h99;
    endcase
  endfunction
endpackage

// File: rtl/calreg_rst_sync.sv
module calreg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = sync_q[STAGES-1];
endmodule

// File: rtl/cal_field_step.sv
module cal_field_step
  import calreg_pkg::*;
(
  input  bcd_t cur_i,
  input  bcd_t first_i,
  input  bcd_t last_i,
  output bcd_t nxt_o,
  output logic wrap_o
);
  always_comb begin
    wrap_o = (cur_i == last_i);
    if (wrap_o)                 nxt_o = first_i;
    else if (cur_i[3:0] >= 4'd9) nxt_o = {cur_i[7:4] + 4'd1, 4'd0};
    else                        nxt_o = {cur_i[7:4], cur_i[3:0] + 4'd1};
  end
endmodule

// File: rtl/cal_month_end.sv
module cal_month_end
  import calreg_pkg::*;
(
  input  bcd_t       month_i,
  input  logic       yr_tens_lsb_i,
  input  logic [1:0] yr_ones_low_i,
  output bcd_t       last_date_o
);
  logic [1:0] yr_mod4;
  logic       leap;

  always_comb begin
    yr_mod4 = {yr_tens_lsb_i, 1'b0} + yr_ones_low_i;
    leap    = (yr_mod4 == 2'd0);
    case (month_i)
      8'h02:                      last_date_o = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_date_o = 8'h30;
      default:                    last_date_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/calendar_regfile.sv
module calendar_regfile
  import calreg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CAL  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_T0   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_TLST = ADDR_W'(NREG - 1);
  localparam int                FW     = 8 * NFIELD;

  logic rst_ns;
  calreg_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  bcd_t live_q [NFIELD];
  bcd_t hold_q [NFIELD];
  bcd_t snap_q [NFIELD];
  bcd_t live_d [NFIELD];
  bcd_t hold_d [NFIELD];
  bcd_t step_nxt [NFIELD];
  bcd_t last_lim [NFIELD];
  logic [NFIELD-1:0] step_wrap, fen;
  logic r_q, w_q, stop_q, tamp_q, cal_s_q;
  logic [4:0] cal_m_q;
  bcd_t date_last;

  // Decode
  logic wr_ctl, wr_cal, wr_fld, count_ok, take_snap, take_hold, load_hold;
  logic live_en, hold_en;
  logic [ADDR_W-1:0] fofs;

  always_comb begin
    fofs      = addr_i - A_T0;
    wr_ctl    = wr_en_i && (addr_i == A_CTL);
    wr_cal    = wr_en_i && (addr_i == A_CAL);
    wr_fld    = wr_en_i && (addr_i >= A_T0) && (addr_i <= A_TLST);
    count_ok  = tick_i && !w_q && !stop_q;
    take_snap = wr_ctl && !r_q && wdata_i[0];
    take_hold = wr_ctl && !w_q && wdata_i[1];
    load_hold = wr_ctl && w_q && !wdata_i[1];
    live_en   = load_hold || count_ok;
    hold_en   = take_hold || (w_q && wr_fld);
  end

  // Counter chain
  cal_month_end u_mend (
    .month_i(live_q[F_MON]), .yr_tens_lsb_i(live_q[F_YEAR][4]),
    .yr_ones_low_i(live_q[F_YEAR][1:0]), .last_date_o(date_last));

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    if (g == F_DATE) begin : g_dyn
      assign last_lim[g] = date_last;
    end else begin : g_fix
      assign last_lim[g] = field_last(g);
    end
    cal_field_step u_step (
      .cur_i(live_q[g]), .first_i(field_first(g)), .last_i(last_lim[g]),
      .nxt_o(step_nxt[g]), .wrap_o(step_wrap[g]));
  end

  always_comb begin
    fen[F_SEC]  = count_ok;
    fen[F_MIN]  = fen[F_SEC]  && step_wrap[F_SEC];
    fen[F_HOUR] = fen[F_MIN]  && step_wrap[F_MIN];
    fen[F_DAY]  = fen[F_HOUR] && step_wrap[F_HOUR];
    fen[F_DATE] = fen[F_HOUR] && step_wrap[F_HOUR];
    fen[F_MON]  = fen[F_DATE] && step_wrap[F_DATE];
    fen[F_YEAR] = fen[F_MON]  && step_wrap[F_MON];
  end

  // Next state
  always_comb begin
    for (int i = 0; i < NFIELD; i++) begin
      if (load_hold)   live_d[i] = hold_q[i];
      else if (fen[i]) live_d[i] = step_nxt[i];
      else             live_d[i] = live_q[i];
      if (take_hold)                        hold_d[i] = live_q[i];
      else if (fofs == ADDR_W'(i) && wr_fld) hold_d[i] = wdata_i & field_mask(i);
      else                                  hold_d[i] = hold_q[i];
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      for (int i = 0; i < NFIELD; i++) begin
        live_q[i] <= field_first(i);
        hold_q[i] <= field_first(i);
        snap_q[i] <= field_first(i);
      end
      r_q <= 1'b0; w_q <= 1'b0; stop_q <= 1'b0; tamp_q <= 1'b0;
      cal_s_q <= 1'b0; cal_m_q <= '0;
    end else begin
      if (live_en)   live_q <= live_d;
      if (hold_en)   hold_q <= hold_d;
      if (take_snap) snap_q <= live_q;
      if (wr_ctl) begin
        r_q    <= wdata_i[0];
        w_q    <= wdata_i[1];
        tamp_q <= wdata_i[6];
        stop_q <= wdata_i[7];
      end
      if (wr_cal) begin
        cal_s_q <= wdata_i[5];
        cal_m_q <= wdata_i[4:0];
      end
    end
  end

  // Read port
  always_comb begin
    rdata_o = 8'h00;
    if (addr_i == A_CTL)      rdata_o = {stop_q, tamp_q, 4'b0000, w_q, r_q};
    else if (addr_i == A_CAL) rdata_o = {2'b00, cal_s_q, cal_m_q};
    else begin
      for (int i = 0; i < NFIELD; i++)
        if (fofs == ADDR_W'(i)) rdata_o = snap_q[i];
    end
  end

  // Assertions
  logic [FW-1:0] live_flat, snap_flat;
  for (genvar g = 0; g < NFIELD; g++) begin : g_flat
    assign live_flat[8*g +: 8] = live_q[g];
    assign snap_flat[8*g +: 8] = snap_q[g];
  end

  assert_hold_freeze_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    (w_q && !wr_ctl) |=> $stable(live_flat));
  assert_stop_freeze_R6: assert property (@(posedge clk) disable iff (!rst_ns)
    (stop_q && !w_q) |=> $stable(live_flat));
  assert_snap_copy_R7: assert property (@(posedge clk) disable iff (!rst_ns)
    take_snap |=> (snap_flat == $past(live_flat)));
  assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    (count_ok && live_q[F_SEC] == 8'h59) |=> (live_q[F_SEC] == 8'h00));
  assert_sec_digit_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    (live_q[F_SEC][3:0] <= 4'd9) && (live_q[F_SEC] <= 8'h59));
  assert_day_range_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    (live_q[F_DAY] >= 8'h01) && (live_q[F_DAY] <= 8'h07));
  assert_year_roll_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    (fen[F_YEAR] && step_wrap[F_YEAR]) |=> (live_q[F_YEAR] == 8'h00));
endmodule

// File: tb/calendar_regfile_tb.sv
module calendar_regfile_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [3:0] addr_i = 4'd0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;

  int checks = 0;
  int errors = 0;
  bit active = 1'b0;
  bit done = 1'b0;
  string req = "R10";

  always #2ns clk = ~clk;

  calendar_regfile #(.ADDR_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o));

  // Reference model
  int m_live[7], m_hold[7], m_snap[7];
  bit m_r, m_w, m_stop, m_tamp, m_cs;
  logic [4:0] m_cm;
  int masks[7] = '{127, 127, 63, 7, 63, 31, 255};

  function automatic logic [7:0] to_bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int from_bcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int month_days(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  task automatic model_reset();
    m_live = '{0, 0, 0, 1, 1, 1, 0};
    m_hold = m_live;
    m_snap = m_live;
    {m_r, m_w, m_stop, m_tamp, m_cs} = '0;
    m_cm = '0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int old_live[7];
      bit ctl;
      old_live = m_live;
      ctl = wr_en_i && addr_i == 4'd0;
      if (ctl && m_w && !wdata_i[1]) m_live = m_hold;
      else if (tick_i && !m_w && !m_stop) begin
        m_live[0]++;
        if (m_live[0] == 60) begin
          m_live[0] = 0; m_live[1]++;
          if (m_live[1] == 60) begin
            m_live[1] = 0; m_live[2]++;
            if (m_live[2] == 24) begin
              m_live[2] = 0;
              m_live[3] = (m_live[3] % 7) + 1;
              m_live[4]++;
              if (m_live[4] > month_days(m_live[5], m_live[6])) begin
                m_live[4] = 1; m_live[5]++;
                if (m_live[5] == 13) begin
                  m_live[5] = 1;
                  m_live[6] = (m_live[6] + 1) % 100;
                end
              end
            end
          end
        end
      end
      if (ctl && !m_r && wdata_i[0]) m_snap = old_live;
      if (ctl && !m_w && wdata_i[1]) m_hold = old_live;
      else if (wr_en_i && m_w && addr_i >= 4'd2 && addr_i <= 4'd8)
        m_hold[addr_i - 2] = from_bcd(wdata_i & 8'(masks[addr_i - 2]));
      if (ctl) begin
        m_r = wdata_i[0]; m_w = wdata_i[1]; m_tamp = wdata_i[6]; m_stop = wdata_i[7];
      end
      if (wr_en_i && addr_i == 4'd1) begin
        m_cs = wdata_i[5]; m_cm = wdata_i[4:0];
      end
    end
  end

  function automatic logic [7:0] exp_read(int a);
    if (a == 0) return {m_stop, m_tamp, 4'b0000, m_w, m_r};
    if (a == 1) return {2'b00, m_cs, m_cm};
    if (a >= 2 && a <= 8) return to_bcd(m_snap[a - 2]);
    return 8'h00;
  endfunction

  // Every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (active && !done) begin
      logic [7:0] e;
      e = exp_read(int'(addr_i));
      checks++;
      if (rdata_o !== e) begin
        errors++;
        $display("FAIL %s model addr %0d actual %02h expected %02h", req, addr_i, rdata_o, e);
      end
    end
  end

  // Stimulus
  task automatic op(bit w, int a, logic [7:0] d, bit t);
    @(posedge clk); #1;
    wr_en_i = w; addr_i = 4'(a); wdata_i = d; tick_i = t;
  endtask

  task automatic wr(int a, logic [7:0] d);
    op(1'b1, a, d, 1'b0);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) op(1'b0, int'($urandom % 16), 8'h00, 1'b1);
  endtask

  task automatic expect_reg(int a, logic [7:0] e, string tag);
    op(1'b0, a, 8'h00, 1'b0);
    @(negedge clk);
    checks++;
    if (rdata_o !== e) begin
      errors++;
      $display("FAIL %s addr %0d actual %02h expected %02h", tag, a, rdata_o, e);
    end
  endtask

  task automatic peek(logic [7:0] base);
    wr(0, base);
    wr(0, base | 8'h01);
    for (int a = 0; a < 9; a++) op(1'b0, a, 8'h00, 1'b0);
  endtask

  task automatic set_time(int h, int mi, int s, int dw, int dt, int mo, int yr);
    wr(0, 8'h02);
    op(1'b0, 2, 8'h00, 1'b1);
    wr(2, to_bcd(s)); wr(3, to_bcd(mi)); wr(4, to_bcd(h));
    wr(5, to_bcd(dw)); wr(6, to_bcd(dt)); wr(7, to_bcd(mo)); wr(8, to_bcd(yr));
    wr(0, 8'h00);
  endtask

  task automatic expect_date(logic [7:0] dw, logic [7:0] dt, logic [7:0] mo,
                             logic [7:0] yr, string tag);
    expect_reg(5, dw, tag); expect_reg(6, dt, tag);
    expect_reg(7, mo, tag); expect_reg(8, yr, tag);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    active = 1'b1;
    repeat (4) op(1'b0, 0, 8'h00, 1'b0);

    req = "R10";
    expect_reg(0, 8'h00, "R10"); expect_reg(1, 8'h00, "R10");
    expect_reg(2, 8'h00, "R10"); expect_reg(4, 8'h00, "R10");
    expect_date(8'h01, 8'h01, 8'h01, 8'h00, "R10");
    req = "R1";
    expect_reg(9, 8'h00, "R1"); expect_reg(15, 8'h00, "R1");

    req = "R9";
    wr(1, 8'hFF); expect_reg(1, 8'h3F, "R9");
    wr(1, 8'h25); expect_reg(1, 8'h25, "R9");
    wr(0, 8'hFC); expect_reg(0, 8'hC0, "R1");
    wr(0, 8'h40); ticks(3); peek(8'h40);
    expect_reg(2, 8'h03, "R9");
    wr(0, 8'h00);

    req = "R8";
    set_time(23, 59, 58, 7, 28, 2, 3);
    peek(8'h00); expect_reg(2, 8'h58, "R8"); expect_reg(4, 8'h23, "R8");
    req = "R2";
    ticks(2); peek(8'h00);
    expect_reg(2, 8'h00, "R2"); expect_reg(3, 8'h00, "R2"); expect_reg(4, 8'h00, "R2");
    req = "R4";
    expect_date(8'h01, 8'h01, 8'h03, 8'h03, "R4");
    req = "R8";
    wr(2, 8'h33); peek(8'h00); expect_reg(2, 8'h00, "R8");

    req = "R4";
    set_time(23, 59, 59, 2, 28, 2, 24); ticks(1); peek(8'h00);
    expect_date(8'h03, 8'h29, 8'h02, 8'h24, "R4");
    set_time(23, 59, 59, 3, 29, 2, 24); ticks(1); peek(8'h00);
    expect_date(8'h04, 8'h01, 8'h03, 8'h24, "R4");
    set_time(23, 59, 59, 4, 30, 4, 10); ticks(1); peek(8'h00);
    expect_date(8'h05, 8'h01, 8'h05, 8'h10, "R4");
    set_time(23, 59, 59, 6, 31, 1, 1); ticks(1); peek(8'h00);
    expect_date(8'h07, 8'h01, 8'h02, 8'h01, "R4");
    set_time(23, 59, 59, 1, 30, 11, 1); ticks(1); peek(8'h00);
    expect_date(8'h02, 8'h01, 8'h12, 8'h01, "R4");

    req = "R5";
    set_time(23, 59, 59, 5, 31, 12, 99); ticks(1); peek(8'h00);
    expect_date(8'h06, 8'h01, 8'h01, 8'h00, "R5");

    req = "R3";
    set_time(23, 59, 59, 7, 10, 6, 50); ticks(1); peek(8'h00);
    expect_reg(5, 8'h01, "R3");

    req = "R6";
    wr(0, 8'h80); ticks(5); peek(8'h80);
    expect_reg(2, 8'h00, "R6");
    wr(0, 8'h00); ticks(3); peek(8'h00);
    expect_reg(2, 8'h03, "R6");

    req = "R7";
    ticks(4); expect_reg(2, 8'h03, "R7");
    peek(8'h00); expect_reg(2, 8'h07, "R7");

    req = "R2";
    set_time(22, 58, 0, 3, 15, 8, 20);
    for (int k = 0; k < 12; k++) begin
      ticks(320);
      peek(8'h00);
    end
    expect_reg(4, 8'h00, "R2"); expect_reg(3, 8'h02, "R2"); expect_reg(2, 8'h00, "R2");

    op(1'b0, 0, 8'h00, 1'b0);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog %s actual timeout expected completion", req);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule